// File: doc/BRIEF.md
# HI/LO multiply-divide unit

This block performs 32-bit integer multiplication and division for a processor core and keeps the 64-bit outcome in a pair of result registers, HI and LO. A command is issued by raising `start_i` for one cycle with an operation code and two operands. Multiplies and divides run over several cycles; `busy_o` stays high while they run, and `done_o` pulses for one cycle when the result lands. Commands that only write HI or LO complete in a single cycle. The current contents of HI and LO are always visible on `hi_o` and `lo_o`, which is how the core reads them.

Multiplication reuses one half-width multiplier over four cycles. Each operand is split into an upper and a lower half. The four cross products are accumulated through an explicit middle-column sum, which carries into the upper word. Signed multiplication works on magnitudes. When the operand signs differ, it negates the 64-bit pair as a whole, so that a carry out of LO reaches HI. Division is restoring, one quotient bit per cycle. It leaves the quotient in LO and the remainder in HI. A zero divisor leaves both registers untouched and raises no error.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After a synchronous active-low reset, `hi_o` and `lo_o` are zero and `busy_o` and `done_o` are low.
- R2: Operation code 1 (unsigned multiply) writes the full 64-bit unsigned product of `opa_i` and `opb_i`, upper word to HI and lower word to LO.
- R3: Operation code 0 (signed multiply) writes the 64-bit two's-complement product, including operands of 0x80000000 and products whose negation carries from LO into HI (zero times a negative value gives zero).
- R4: Operation code 2 (signed divide) writes the quotient truncated toward zero to LO and the remainder, with the sign of the dividend, to HI; 0x80000000 divided by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R5: Operation code 3 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R6: A divide (code 2 or 3) with `opb_i` equal to zero leaves HI and LO unchanged, never raises `busy_o`, and pulses `done_o` in the cycle after acceptance.
- R7: Operation code 4 copies `opa_i` into HI and code 5 copies `opa_i` into LO, leaving the other register unchanged, with `done_o` in the cycle after acceptance.
- R8: An accepted multiply or divide with a nonzero divisor raises `busy_o` in the next cycle. `busy_o` falls in the cycle in which `done_o` pulses. HI and LO change only in a cycle where `done_o` is high.
- R9: A `start_i` raised while `busy_o` is high is ignored: it produces no extra `done_o` and does not alter HI or LO.
- R10: Operation codes 6 and 7 change neither HI nor LO and still pulse `done_o` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Command request, sampled when `busy_o` is low |
| op_i | input | 3 | Operation code (0..7, see requirements) |
| opa_i | input | DATA_W | First operand / dividend / value to move |
| opb_i | input | DATA_W | Second operand / divisor |
| busy_o | output | 1 | Multi-cycle operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | DATA_W | Current HI register |
| lo_o | output | DATA_W | Current LO register |

## Verification
The bench builds the unit at the default `DATA_W` of 32, which makes each half 16 bits wide. Operands such as 0x0001FFFF and all-ones therefore drive carries out of the middle column and across the half boundary. At that width the bench can also reach the most-negative operand in both signed multiply and signed divide, and zero times a negative number, which forces the LO-to-HI carry during negation. The same build reaches divisors of zero for both divide flavours and a dividend smaller than the divisor. Directed cases are mixed with a seeded run of random multiplies and divides, and the bench checks each result against 64-bit arithmetic of its own.

// File: rtl/hilo_pkg.sv
// Package: shared command codes and sequencer states for the HI/LO
// multiply-divide unit. Assumes a 3-bit command field.
package hilo_pkg;

    // Command codes presented on op_i
    typedef enum logic [2:0] {
        OP_MUL_S  = 3'd0,
        OP_MUL_U  = 3'd1,
        OP_DIV_S  = 3'd2,
        OP_DIV_U  = 3'd3,
        OP_SET_HI = 3'd4,
        OP_SET_LO = 3'd5
    } hilo_op_e;

    // Sequencer states shared by both arithmetic engines
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WORK = 2'd1,
        SQ_SIGN = 2'd2
    } seq_state_e;

endpackage

// File: rtl/hilo_mul_seq.sv
// Module: iterative multiplier. Forms a DATA_W x DATA_W product from four
// half-width partial products on one shared multiplier, merges them through
// an explicit middle-column sum, then negates the 64-bit pair when the
// signed result is negative. Assumes DATA_W is even and that start_i is
// only raised while the sequencer is idle.
module hilo_mul_seq
    import hilo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signed_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] hi_o,
    output logic [DATA_W-1:0] lo_o
);

    localparam int HALF_W = DATA_W / 2;
    localparam int MID_W  = DATA_W + 2;

    seq_state_e        state_q;
    logic [1:0]        step_q;
    logic [DATA_W-1:0] mag_a_q, mag_b_q;
    logic              neg_q;
    logic [MID_W-1:0]  mid_q;
    logic [DATA_W-1:0] hi_q, lo_q;
    logic              valid_q;

    logic [HALF_W-1:0] fac_x, fac_y;
    logic [DATA_W-1:0] part;
    logic [DATA_W-1:0] lo_neg, hi_neg;
    logic              a_neg, b_neg;

    // Purpose: select the halves that feed the shared multiplier this step
    always_comb begin
        unique case (step_q)
            2'd0:    begin fac_x = mag_a_q[HALF_W-1:0];      fac_y = mag_b_q[HALF_W-1:0]; end
            2'd1:    begin fac_x = mag_a_q[DATA_W-1:HALF_W]; fac_y = mag_b_q[HALF_W-1:0]; end
            2'd2:    begin fac_x = mag_b_q[DATA_W-1:HALF_W]; fac_y = mag_a_q[HALF_W-1:0]; end
            default: begin fac_x = mag_a_q[DATA_W-1:HALF_W]; fac_y = mag_b_q[DATA_W-1:HALF_W]; end
        endcase
        part = DATA_W'(fac_x) * DATA_W'(fac_y);
    end

    // Purpose: operand signs and the two's-complement of the 64-bit pair
    always_comb begin
        a_neg  = signed_i & a_i[DATA_W-1];
        b_neg  = signed_i & b_i[DATA_W-1];
        lo_neg = ~lo_q + 1'b1;
        hi_neg = ~hi_q + DATA_W'(lo_neg == '0);
    end

    // Purpose: step through load, four partial products and sign fix-up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            step_q  <= '0;
            mag_a_q <= '0;
            mag_b_q <= '0;
            neg_q   <= 1'b0;
            mid_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        mag_a_q <= a_neg ? (~a_i + 1'b1) : a_i;
                        mag_b_q <= b_neg ? (~b_i + 1'b1) : b_i;
                        neg_q   <= a_neg ^ b_neg;
                        step_q  <= '0;
                        state_q <= SQ_WORK;
                    end
                end
                SQ_WORK: begin
                    step_q <= step_q + 2'd1;
                    unique case (step_q)
                        2'd0: begin
                            lo_q[HALF_W-1:0] <= part[HALF_W-1:0];
                            mid_q            <= MID_W'(part[DATA_W-1:HALF_W]);
                        end
                        2'd1, 2'd2: begin
                            mid_q <= mid_q + MID_W'(part);
                        end
                        default: begin
                            lo_q[DATA_W-1:HALF_W] <= mid_q[HALF_W-1:0];
                            hi_q    <= DATA_W'(mid_q >> HALF_W) + part;
                            state_q <= SQ_SIGN;
                        end
                    endcase
                end
                SQ_SIGN: begin
                    if (neg_q) begin
                        lo_q <= lo_neg;
                        hi_q <= hi_neg;
                    end
                    valid_q <= 1'b1;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign valid_o = valid_q;
    assign hi_o    = hi_q;
    assign lo_o    = lo_q;

endmodule

// File: rtl/hilo_div_seq.sv
// Module: restoring divider, one quotient bit per cycle. Signed operation
// divides magnitudes, then gives the quotient the XOR of the operand signs
// and the remainder the dividend's sign. Assumes a nonzero divisor and
// start_i only while idle.
module hilo_div_seq
    import hilo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signed_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] quo_o,
    output logic [DATA_W-1:0] rem_o
);

    localparam int CNT_W  = $clog2(DATA_W);
    localparam int DIFF_W = DATA_W + 2;

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] quo_q, rem_q, dvs_q;
    logic              qneg_q, rneg_q;
    logic              valid_q;

    logic [DIFF_W-1:0] shifted, diff;
    logic              a_neg, b_neg;

    // Purpose: trial subtraction of the divisor from the shifted remainder
    always_comb begin
        a_neg   = signed_i & a_i[DATA_W-1];
        b_neg   = signed_i & b_i[DATA_W-1];
        shifted = DIFF_W'({rem_q, quo_q[DATA_W-1]});
        diff    = shifted - DIFF_W'(dvs_q);
    end

    // Purpose: load magnitudes, iterate DATA_W steps, then restore signs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
            qneg_q  <= 1'b0;
            rneg_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        quo_q   <= a_neg ? (~a_i + 1'b1) : a_i;
                        dvs_q   <= b_neg ? (~b_i + 1'b1) : b_i;
                        rem_q   <= '0;
                        cnt_q   <= '0;
                        qneg_q  <= a_neg ^ b_neg;
                        rneg_q  <= a_neg;
                        state_q <= SQ_WORK;
                    end
                end
                SQ_WORK: begin
                    if (!diff[DIFF_W-1]) begin
                        rem_q <= diff[DATA_W-1:0];
                        quo_q <= {quo_q[DATA_W-2:0], 1'b1};
                    end else begin
                        rem_q <= shifted[DATA_W-1:0];
                        quo_q <= {quo_q[DATA_W-2:0], 1'b0};
                    end
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(DATA_W - 1)) state_q <= SQ_SIGN;
                end
                SQ_SIGN: begin
                    if (qneg_q) quo_q <= ~quo_q + 1'b1;
                    if (rneg_q) rem_q <= ~rem_q + 1'b1;
                    valid_q <= 1'b1;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign valid_o = valid_q;
    assign quo_o   = quo_q;
    assign rem_o   = rem_q;

endmodule

// File: rtl/hilo_muldiv_unit.sv
// Module: top of the HI/LO multiply-divide unit. Decodes commands, launches
// the multiply or divide sequencer, applies the zero-divisor rule, and owns
// the HI and LO registers. Assumes start_i is a one-cycle request; requests
// arriving while busy are dropped.
module hilo_muldiv_unit
    import hilo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] hi_o,
    output logic [DATA_W-1:0] lo_o
);

    logic [DATA_W-1:0] hi_q, lo_q;
    logic              busy_q, done_q;
    logic              accept, is_mul, is_div, div_zero;
    logic              mul_go, div_go;
    logic              mul_valid, div_valid;
    logic [DATA_W-1:0] mul_hi, mul_lo, div_quo, div_rem;

    // Purpose: decode an accepted command into engine launches
    always_comb begin
        accept   = start_i & ~busy_q;
        is_mul   = (op_i == OP_MUL_S) | (op_i == OP_MUL_U);
        is_div   = (op_i == OP_DIV_S) | (op_i == OP_DIV_U);
        div_zero = (opb_i == '0);
        mul_go   = accept & is_mul;
        div_go   = accept & is_div & ~div_zero;
    end

    hilo_mul_seq #(.DATA_W(DATA_W)) i_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (mul_go),
        .signed_i (op_i == OP_MUL_S),
        .a_i      (opa_i),
        .b_i      (opb_i),
        .valid_o  (mul_valid),
        .hi_o     (mul_hi),
        .lo_o     (mul_lo)
    );

    hilo_div_seq #(.DATA_W(DATA_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (div_go),
        .signed_i (op_i == OP_DIV_S),
        .a_i      (opa_i),
        .b_i      (opb_i),
        .valid_o  (div_valid),
        .quo_o    (div_quo),
        .rem_o    (div_rem)
    );

    // Purpose: HI/LO register file, busy flag and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (is_mul || (is_div && !div_zero)) begin
                    busy_q <= 1'b1;
                end else begin
                    if (op_i == OP_SET_HI) hi_q <= opa_i;
                    if (op_i == OP_SET_LO) lo_q <= opa_i;
                    done_q <= 1'b1;
                end
            end
            if (mul_valid) begin
                hi_q   <= mul_hi;
                lo_q   <= mul_lo;
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
            if (div_valid) begin
                hi_q   <= div_rem;
                lo_q   <= div_quo;
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign hi_o   = hi_q;
    assign lo_o   = lo_q;

endmodule

// File: rtl/hilo_muldiv_chk.sv
// Module: protocol checker for the HI/LO multiply-divide unit, bound to
// the top. Observes ports only.
module hilo_muldiv_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [2:0]        op_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] hi_o,
    input logic [DATA_W-1:0] lo_o
);

    // R8: busy ends only together with the completion pulse
    a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8: the completion pulse never overlaps busy
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: HI and LO only move in a completion cycle
    a_r8_hold_outside_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));

    // R8: an accepted multiply raises busy next cycle
    a_r8_mul_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i <= 3'd1) |=> busy_o);

    // R6: zero divisor leaves HI/LO alone and completes at once
    a_r6_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i == 3'd2 || op_i == 3'd3) && opb_i == '0)
        |=> (done_o && !busy_o && $stable(hi_o) && $stable(lo_o)));

    // R7: move to HI copies the operand and keeps LO
    a_r7_set_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i == 3'd4)
        |=> (done_o && hi_o == $past(opa_i) && $stable(lo_o)));

    // R7: move to LO copies the operand and keeps HI
    a_r7_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i == 3'd5)
        |=> (done_o && lo_o == $past(opa_i) && $stable(hi_o)));

    // R9: while busy, the next cycle is still busy or the completion
    a_r9_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    // R10: unused codes complete without touching HI/LO
    a_r10_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i >= 3'd6)
        |=> (done_o && $stable(hi_o) && $stable(lo_o)));

endmodule

bind hilo_muldiv_unit hilo_muldiv_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_hilo_muldiv_unit.sv
// Scoreboard bench: the driver computes expected HI/LO with 64-bit
// arithmetic and queues them; the monitor pops one per done pulse.
module test_hilo_muldiv_unit;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [2:0]   op_i = '0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] hi_o, lo_o;

    always #5 clk = ~clk;

    hilo_muldiv_unit #(.DATA_W(W)) i_hilo_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [W-1:0] m_hi = '0, m_lo = '0;
    logic [63:0] mon_exp;
    string       mon_tag;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each completion against the queued expectation
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 done without pending command", {hi_o, lo_o}, 64'd0);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                check({hi_o, lo_o} == mon_exp, mon_tag, {hi_o, lo_o}, mon_exp);
                check(!busy_o, "R8 busy low at done", 64'(busy_o), 64'd0);
            end
        end
    end

    // Driver: model the command, queue the result, pulse start for one cycle
    task automatic issue_nowait(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        longint      sp, sa, sb;
        logic [63:0] up, ua, ub;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = {32'd0, a};
        ub = {32'd0, b};
        case (op)
            3'd0: begin sp = sa * sb; m_hi = sp[63:32]; m_lo = sp[31:0]; end
            3'd1: begin up = ua * ub; m_hi = up[63:32]; m_lo = up[31:0]; end
            3'd2: if (b != 0) begin sp = sa / sb; m_lo = sp[31:0]; sp = sa % sb; m_hi = sp[31:0]; end
            3'd3: if (b != 0) begin up = ua / ub; m_lo = up[31:0]; up = ua % ub; m_hi = up[31:0]; end
            3'd4: m_hi = a;
            3'd5: m_lo = a;
            default: ;
        endcase
        exp_q.push_back({m_hi, m_lo});
        tag_q.push_back(tag);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        issue_nowait(op, a, b, tag);
        wait_empty();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(hi_o == 0 && lo_o == 0, "R1 HI/LO zero after reset", {hi_o, lo_o}, 64'd0);
        check(!busy_o && !done_o, "R1 busy/done low after reset", {62'd0, busy_o, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: unsigned multiply
        issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 umul all ones");
        issue(3'd1, 32'h1234_5678, 32'h9ABC_DEF0, "R2 umul mixed");
        issue(3'd1, 32'h0001_FFFF, 32'h0001_FFFF, "R2 umul middle carry");
        // R3: signed multiply
        issue(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 smul -1*-1");
        issue(3'd0, 32'h8000_0000, 32'h8000_0000, "R3 smul min*min");
        issue(3'd0, 32'hFFFF_FFFD, 32'd5, "R3 smul -3*5");
        issue(3'd0, 32'h8000_0000, 32'd1, "R3 smul min*1");
        issue(3'd0, 32'd0, 32'hFFFF_FFFB, "R3 smul 0*-5 carry into HI");
        // R4: signed divide
        issue(3'd2, 32'hFFFF_FFF9, 32'd2, "R4 sdiv -7/2");
        issue(3'd2, 32'd7, 32'hFFFF_FFFE, "R4 sdiv 7/-2");
        issue(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R4 sdiv min/-1");
        // R5: unsigned divide
        issue(3'd3, 32'hFFFF_FFFF, 32'd3, "R5 udiv max/3");
        issue(3'd3, 32'd100, 32'd7, "R5 udiv 100/7");
        issue(3'd3, 32'd5, 32'hFFFF_FFFF, "R5 udiv small/large");
        // R7: moves
        issue(3'd4, 32'hCAFE_0001, 32'd0, "R7 move to HI");
        issue(3'd5, 32'h0BAD_F00D, 32'd0, "R7 move to LO");
        // R6: zero divisor leaves registers alone
        issue(3'd2, 32'd1234, 32'd0, "R6 sdiv by zero unchanged");
        issue(3'd3, 32'hFFFF_0000, 32'd0, "R6 udiv by zero unchanged");
        // R10: unused codes
        issue(3'd6, 32'h1111_1111, 32'd2, "R10 code 6 no effect");
        issue(3'd7, 32'h2222_2222, 32'd3, "R10 code 7 no effect");

        // R8/R9: busy during a multiply, a second start while busy is dropped
        issue_nowait(3'd1, 32'h0000_FFFF, 32'h0001_0001, "R9 result of first command kept");
        check(busy_o, "R8 busy after multiply accepted", 64'(busy_o), 64'd1);
        start_i = 1'b1; op_i = 3'd4; opa_i = 32'hDEAD_BEEF; opb_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        wait_empty();
        repeat (60) @(negedge clk);
        check(hi_o == m_hi, "R9 HI not written by ignored start", 64'(hi_o), 64'(m_hi));

        // R2-R5 mixed: seeded random multiplies and divides
        for (int i = 0; i < 40; i++) begin
            logic [2:0]   rop;
            logic [W-1:0] ra, rb;
            rop = 3'($urandom_range(0, 3));
            ra  = $urandom();
            rb  = (i % 5 == 0) ? 32'(i) : $urandom();
            issue(rop, ra, rb, "R2 R3 R4 R5 random op");
        end

        finish_run();
    end

    initial begin
        void'($urandom(7));
    end

endmodule